// File: doc/BRIEF.md
# Single-Precision Round and Pack Unit

This block converts an unpacked floating-point value into a packed 32-bit single-precision word, together with inexact and overflow flags. The unpacked value arrives as a class code, a sign, a signed unbiased exponent and a 64-bit fraction whose implicit leading one sits at bit 60. The 37 low bits of that fraction are the guard and pad field, and they are discarded during packing. A two-bit selector picks the rounding direction.

All packing is combinational. The result and the flags are captured in output registers on the clock edge that samples a valid strobe. The unit sits at the end of an arithmetic datapath. It turns whatever the datapath computed into the stored format: it rounds, it denormalises small results, it flushes results that are too small to zero, it saturates overflow according to the rounding direction, and it forces the NaN class bit.

Top module: `fpk_pack_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. Result and flags are loaded only on a valid strobe and otherwise keep their value. Reset clears all outputs to zero.
- R2: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN. Codes 5 to 7 pack as signed zero. Zero packs as `{sign, 8'h00, 23'h0}` and infinity as `{sign, 8'hFF, 23'h0}`, both with the flags clear.
- R3: A NaN packs with exponent 8'hFF. Fraction bits 21:0 are taken from input bits 58:37. Fraction bit 22 is forced to 1 for a quiet NaN and to 0 for a signalling NaN. The flags are clear.
- R4: A number input has `in_frac[63:60] == 4'b0001`. With an exponent e in -126..127 and a zero discarded field, the word is `{sign, e+127, in_frac[59:37]}` with the flags clear.
- R5: Rounding mode 2'b00 (nearest-even) increments the retained 23-bit fraction when the discarded field is above one half. When the field is exactly one half (only bit 36 set), it increments only if the retained LSB is 1. Inexact is set whenever the discarded field is nonzero.
- R6: Mode 2'b01 truncates. Mode 2'b10 increments positive values with a nonzero discarded field. Mode 2'b11 increments negative values with a nonzero discarded field.
- R7: An increment that carries out of the mantissa yields a zero fraction and an exponent one higher. If that carry reaches exponent 255, the word is infinity and overflow is flagged.
- R8: An exponent above 127 flags overflow and inexact. The word is infinity for nearest, for up with a positive sign and for down with a negative sign. In every other case it is the largest finite value of that sign, 8'hFE with an all-ones fraction.
- R9: An exponent below -126 gives a biased exponent of 0. The fraction is the 24-bit mantissa `in_frac[60:37]` shifted right by (-126 - e) and truncated. Inexact is set if any dropped bit is nonzero.
- R10: When that shift exceeds 23, the word is a zero carrying the input sign, and inexact is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_class | input | 3 | Class code of the unpacked value |
| in_sign | input | 1 | Sign, 1 for negative |
| in_exp | input | 12 | Signed unbiased exponent |
| in_frac | input | 64 | Fraction, implicit one at bit 60 |
| in_rmode | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 up, 11 down |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Discarded bits were nonzero |
| out_overflow | output | 1 | Exponent exceeded the finite range |

## Verification
The only internal state is the output register, so a wrong capture shows up in the cycle right after the strobe. It appears either as a missing or extra `out_valid`, or as a word that changes while no strobe is present. Faults in the combinational path appear in that same cycle as a wrong field. A mis-decoded tie moves the result LSB by one. A dropped rounding carry leaves the exponent unchanged while the fraction wraps to zero. A wrong overflow choice swaps infinity and the largest finite value for one combination of mode and sign. A wrong denormal shift moves the fraction by a power of two.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fpk_class_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } fpk_rmode_e;

  // Directed mode that moves the magnitude away from zero for this sign
  function automatic logic grows_mag(input fpk_rmode_e m, input logic s);
    return ((m == RM_UP) && !s) || ((m == RM_DOWN) && s);
  endfunction

endpackage

// File: rtl/fpk_round.sv
module fpk_round
  import fpk_pkg::*;
#(
  parameter int MAN_BITS = 23,
  parameter int EXP_BITS = 8,
  parameter int DROP     = 37
) (
  input  logic [MAN_BITS:0]   mant_i,
  input  logic [DROP-1:0]     drop_i,
  input  logic                sign_i,
  input  fpk_rmode_e          mode_i,
  input  logic [EXP_BITS-1:0] exp_i,
  output logic [EXP_BITS-1:0] exp_o,
  output logic [MAN_BITS-1:0] man_o,
  output logic                inexact_o,
  output logic                carry_ovf_o
);
  localparam logic [DROP-1:0]   HALF    = DROP'(1) << (DROP - 1);
  localparam logic [EXP_BITS:0] EXP_TOP = {1'b0, {EXP_BITS{1'b1}}};

  logic                lost, tie, above, inc, carry;
  logic [MAN_BITS+1:0] sum;
  logic [EXP_BITS:0]   exp_up;

  always_comb begin
    lost  = |drop_i;
    tie   = (drop_i == HALF);
    above = (drop_i > HALF);
    case (mode_i)
      RM_NEAR: inc = above | (tie & mant_i[0]);
      RM_ZERO: inc = 1'b0;
      default: inc = lost & grows_mag(mode_i, sign_i);
    endcase
    sum    = {1'b0, mant_i} + (MAN_BITS + 2)'(inc);
    carry  = sum[MAN_BITS+1];
    exp_up = {1'b0, exp_i} + (EXP_BITS + 1)'(carry);
    exp_o  = exp_up[EXP_BITS-1:0];
    // after a carry the sum is a single one above a zero field
    man_o  = carry ? sum[MAN_BITS:1] : sum[MAN_BITS-1:0];
    inexact_o   = lost;
    carry_ovf_o = (exp_up == EXP_TOP);
  end

endmodule

// File: rtl/fpk_denorm.sv
module fpk_denorm #(
  parameter int MAN_BITS = 23,
  parameter int DROP     = 37,
  parameter int SH_W     = 6
) (
  input  logic [MAN_BITS:0]   mant_i,
  input  logic [DROP-1:0]     drop_i,
  input  logic [SH_W-1:0]     shift_i,
  output logic [MAN_BITS-1:0] man_o,
  output logic                inexact_o
);
  logic [MAN_BITS:0] lo_mask;

  always_comb begin
    lo_mask   = ~({(MAN_BITS + 1){1'b1}} << shift_i);
    man_o     = MAN_BITS'(mant_i >> shift_i);
    inexact_o = (|drop_i) | (|(mant_i & lo_mask));
  end

endmodule

// File: rtl/fpk_ovf_sel.sv
module fpk_ovf_sel
  import fpk_pkg::*;
#(
  parameter int MAN_BITS = 23,
  parameter int EXP_BITS = 8
) (
  input  logic                sign_i,
  input  fpk_rmode_e          mode_i,
  output logic [EXP_BITS-1:0] exp_o,
  output logic [MAN_BITS-1:0] man_o
);
  logic to_inf;

  always_comb begin
    to_inf = (mode_i == RM_NEAR) | grows_mag(mode_i, sign_i);
    exp_o  = to_inf ? {EXP_BITS{1'b1}} : {{(EXP_BITS - 1){1'b1}}, 1'b0};
    man_o  = to_inf ? '0 : '1;
  end

endmodule

// File: rtl/fpk_pack_unit.sv
module fpk_pack_unit
  import fpk_pkg::*;
#(
  parameter int EXP_BITS = 8,
  parameter int MAN_BITS = 23,
  parameter int FRAC_W   = 64,
  parameter int IMPL_POS = 60,
  parameter int EIN_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [2:0]                    in_class,
  input  logic                          in_sign,
  input  logic signed [EIN_W-1:0]       in_exp,
  input  logic [FRAC_W-1:0]             in_frac,
  input  logic [1:0]                    in_rmode,
  output logic                          out_valid,
  output logic [EXP_BITS+MAN_BITS:0]    out_word,
  output logic                          out_inexact,
  output logic                          out_overflow
);
  localparam int WORD_W = 1 + EXP_BITS + MAN_BITS;
  localparam int DROP   = IMPL_POS - MAN_BITS;
  localparam int BIAS   = (1 << (EXP_BITS - 1)) - 1;
  localparam int EMIN   = 1 - BIAS;
  localparam int SH_W   = $clog2(MAN_BITS + 1) + 1;
  localparam logic [EXP_BITS-1:0] EXP_ONES = {EXP_BITS{1'b1}};

  fpk_class_e cls;
  fpk_rmode_e mode;
  assign cls  = fpk_class_e'(in_class);
  assign mode = fpk_rmode_e'(in_rmode);

  logic [MAN_BITS:0]   mant;
  logic [DROP-1:0]     drop;
  logic [MAN_BITS-2:0] payload;
  assign mant    = in_frac[IMPL_POS:DROP];
  assign drop    = in_frac[DROP-1:0];
  assign payload = in_frac[IMPL_POS-2:DROP];

  int                  e_i;
  logic                dn_need, dn_flush;
  logic [SH_W-1:0]     dn_shift;
  logic [EXP_BITS-1:0] rn_exp_in;

  always_comb begin
    e_i       = int'(in_exp);
    dn_need   = (e_i < EMIN);
    dn_flush  = ((EMIN - e_i) > MAN_BITS);
    dn_shift  = (dn_need && !dn_flush) ? SH_W'(EMIN - e_i) : '0;
    rn_exp_in = EXP_BITS'(e_i + BIAS);
  end

  logic [EXP_BITS-1:0] rn_exp, ov_exp;
  logic [MAN_BITS-1:0] rn_man, dn_man, ov_man;
  logic                rn_ix, rn_ov, dn_ix;

  fpk_round #(.MAN_BITS(MAN_BITS), .EXP_BITS(EXP_BITS), .DROP(DROP)) round_i (
    .mant_i(mant), .drop_i(drop), .sign_i(in_sign), .mode_i(mode),
    .exp_i(rn_exp_in), .exp_o(rn_exp), .man_o(rn_man),
    .inexact_o(rn_ix), .carry_ovf_o(rn_ov)
  );

  fpk_denorm #(.MAN_BITS(MAN_BITS), .DROP(DROP), .SH_W(SH_W)) denorm_i (
    .mant_i(mant), .drop_i(drop), .shift_i(dn_shift),
    .man_o(dn_man), .inexact_o(dn_ix)
  );

  fpk_ovf_sel #(.MAN_BITS(MAN_BITS), .EXP_BITS(EXP_BITS)) ovf_i (
    .sign_i(in_sign), .mode_i(mode), .exp_o(ov_exp), .man_o(ov_man)
  );

  logic [WORD_W-1:0] nxt_word;
  logic              nxt_ix, nxt_ov;

  always_comb begin
    nxt_word = {in_sign, {(WORD_W - 1){1'b0}}};
    nxt_ix   = 1'b0;
    nxt_ov   = 1'b0;
    case (cls)
      CLS_INF:  nxt_word = {in_sign, EXP_ONES, {MAN_BITS{1'b0}}};
      CLS_QNAN: nxt_word = {in_sign, EXP_ONES, 1'b1, payload};
      CLS_SNAN: nxt_word = {in_sign, EXP_ONES, 1'b0, payload};
      CLS_NUM: begin
        if (e_i > BIAS) begin
          nxt_word = {in_sign, ov_exp, ov_man};
          nxt_ix   = 1'b1;
          nxt_ov   = 1'b1;
        end else if (dn_need) begin
          if (dn_flush) begin
            nxt_ix = 1'b1;
          end else begin
            nxt_word = {in_sign, {EXP_BITS{1'b0}}, dn_man};
            nxt_ix   = dn_ix;
          end
        end else begin
          nxt_word = {in_sign, rn_exp, rn_man};
          nxt_ix   = rn_ix;
          nxt_ov   = rn_ov;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_word     <= '0;
      out_inexact  <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word     <= nxt_word;
        out_inexact  <= nxt_ix;
        out_overflow <= nxt_ov;
      end
    end
  end

  // R1
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_inexact)));
  // R2
  zero_class_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_ZERO) |=> (out_word[WORD_W-2:0] == '0 && !out_inexact && !out_overflow));
  // R3
  qnan_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_QNAN) |=> (out_word[WORD_W-2:MAN_BITS] == EXP_ONES && out_word[MAN_BITS-1]));
  // R4
  num_form_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_NUM) |-> (in_frac[FRAC_W-1:IMPL_POS] == 1));
  // R8
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_overflow) |-> out_inexact);
  // R8
  ovf_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_overflow) |->
      ((out_word[WORD_W-2:MAN_BITS] == EXP_ONES && out_word[MAN_BITS-1:0] == '0) ||
       (out_word[WORD_W-2:MAN_BITS] == {EXP_ONES[EXP_BITS-1:1], 1'b0} && &out_word[MAN_BITS-1:0])));

endmodule

// File: tb/fpk_pack_unit_tb_top.sv
`timescale 1ns/1ps
module fpk_pack_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_class = 3'd0;
  logic        in_sign = 1'b0;
  logic signed [11:0] in_exp = '0;
  logic [63:0] in_frac = '0;
  logic [1:0]  in_rmode = 2'd0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_inexact, out_overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpk_pack_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_word(out_word),
    .out_inexact(out_inexact), .out_overflow(out_overflow)
  );

  typedef struct packed {
    logic [31:0] w;
    logic        ix;
    logic        ov;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  function automatic logic [63:0] mk(input logic [22:0] m, input logic [36:0] d);
    return (64'd1 << 60) | ({41'd0, m} << 37) | {27'd0, d};
  endfunction

  localparam logic [36:0] HALF = 37'h1000000000;

  task automatic send(input logic [2:0] c, input logic s, input int e,
                      input logic [63:0] f, input logic [1:0] m,
                      input logic [31:0] w, input logic ix, input logic ov,
                      input string tag);
    exp_t x;
    @(negedge clk);
    in_valid = 1'b1;
    in_class = c;
    in_sign  = s;
    in_exp   = 12'(e);
    in_frac  = f;
    in_rmode = m;
    x.w = w; x.ix = ix; x.ov = ov;
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected out_valid, word=%h expected none", out_word);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_word !== e.w || out_inexact !== e.ix || out_overflow !== e.ov) begin
          errors++;
          $display("FAIL %s: got word=%h ix=%b ov=%b expected word=%h ix=%b ov=%b",
                   t, out_word, out_inexact, out_overflow, e.w, e.ix, e.ov);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'h0 || out_inexact !== 1'b0 || out_overflow !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got v=%b w=%h expected v=0 w=00000000", out_valid, out_word);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2 zero and infinity
    send(3'd0, 1'b1, 5, mk(23'h1234, 37'h5), 2'd0, 32'h80000000, 1'b0, 1'b0, "R2 neg zero");
    send(3'd2, 1'b0, 0, 64'h0, 2'd0, 32'h7F800000, 1'b0, 1'b0, "R2 pos inf");
    send(3'd2, 1'b1, 0, 64'h0, 2'd3, 32'hFF800000, 1'b0, 1'b0, "R2 neg inf");
    // R3 NaN class forcing
    send(3'd3, 1'b0, 0, mk(23'h000123, 37'h0), 2'd0, 32'h7FC00123, 1'b0, 1'b0, "R3 qnan");
    send(3'd4, 1'b0, 0, mk(23'h400001, 37'h0), 2'd0, 32'h7F800001, 1'b0, 1'b0, "R3 snan");
    // R4 exact normal numbers
    send(3'd1, 1'b0, 0, mk(23'h0, 37'h0), 2'd0, 32'h3F800000, 1'b0, 1'b0, "R4 one");
    send(3'd1, 1'b0, -126, mk(23'h5, 37'h0), 2'd0, 32'h00800005, 1'b0, 1'b0, "R4 min normal");
    send(3'd1, 1'b1, 127, mk(23'h7FFFFF, 37'h0), 2'd1, 32'hFF7FFFFF, 1'b0, 1'b0, "R4 max finite");
    // R5 nearest-even
    send(3'd1, 1'b0, 0, mk(23'h2, HALF), 2'd0, 32'h3F800002, 1'b1, 1'b0, "R5 tie even stays");
    send(3'd1, 1'b0, 0, mk(23'h3, HALF), 2'd0, 32'h3F800004, 1'b1, 1'b0, "R5 tie odd up");
    send(3'd1, 1'b0, 0, mk(23'h3, HALF - 37'd1), 2'd0, 32'h3F800003, 1'b1, 1'b0, "R5 below half");
    send(3'd1, 1'b1, 0, mk(23'h2, HALF + 37'd1), 2'd0, 32'hBF800003, 1'b1, 1'b0, "R5 above half");
    // R6 directed modes
    send(3'd1, 1'b0, 0, mk(23'h3, 37'h1FFFFFFFFF), 2'd1, 32'h3F800003, 1'b1, 1'b0, "R6 toward zero");
    send(3'd1, 1'b0, 0, mk(23'h3, 37'h1), 2'd2, 32'h3F800004, 1'b1, 1'b0, "R6 up positive");
    send(3'd1, 1'b1, 0, mk(23'h3, 37'h1), 2'd2, 32'hBF800003, 1'b1, 1'b0, "R6 up negative");
    send(3'd1, 1'b1, 0, mk(23'h3, 37'h1), 2'd3, 32'hBF800004, 1'b1, 1'b0, "R6 down negative");
    send(3'd1, 1'b0, 0, mk(23'h3, 37'h1), 2'd3, 32'h3F800003, 1'b1, 1'b0, "R6 down positive");
    // R7 rounding carry
    send(3'd1, 1'b0, 0, mk(23'h7FFFFF, HALF + 37'd1), 2'd0, 32'h40000000, 1'b1, 1'b0, "R7 carry bumps exp");
    send(3'd1, 1'b0, 127, mk(23'h7FFFFF, HALF), 2'd0, 32'h7F800000, 1'b1, 1'b1, "R7 carry to inf");
    // R8 overflow per mode and sign
    send(3'd1, 1'b0, 128, mk(23'h0, 37'h0), 2'd0, 32'h7F800000, 1'b1, 1'b1, "R8 nearest");
    send(3'd1, 1'b0, 128, mk(23'h0, 37'h0), 2'd1, 32'h7F7FFFFF, 1'b1, 1'b1, "R8 zero");
    send(3'd1, 1'b0, 300, mk(23'h0, 37'h0), 2'd2, 32'h7F800000, 1'b1, 1'b1, "R8 up pos");
    send(3'd1, 1'b1, 128, mk(23'h0, 37'h0), 2'd2, 32'hFF7FFFFF, 1'b1, 1'b1, "R8 up neg");
    send(3'd1, 1'b1, 2000, mk(23'h0, 37'h0), 2'd3, 32'hFF800000, 1'b1, 1'b1, "R8 down neg");
    send(3'd1, 1'b0, 128, mk(23'h0, 37'h0), 2'd3, 32'h7F7FFFFF, 1'b1, 1'b1, "R8 down pos");
    // R9 denormalisation
    send(3'd1, 1'b0, -127, mk(23'h0, 37'h0), 2'd0, 32'h00400000, 1'b0, 1'b0, "R9 shift one");
    send(3'd1, 1'b0, -127, mk(23'h1, 37'h0), 2'd0, 32'h00400000, 1'b1, 1'b0, "R9 lost lsb");
    send(3'd1, 1'b0, -149, mk(23'h0, 37'h0), 2'd0, 32'h00000001, 1'b0, 1'b0, "R9 shift 23");
    send(3'd1, 1'b1, -130, mk(23'h0, 37'h5), 2'd2, 32'h80080000, 1'b1, 1'b0, "R9 negative guard");
    // R10 flush to zero
    send(3'd1, 1'b1, -150, mk(23'h0, 37'h0), 2'd0, 32'h80000000, 1'b1, 1'b0, "R10 shift 24");
    send(3'd1, 1'b0, -2000, mk(23'h7FFFFF, 37'h0), 2'd2, 32'h00000000, 1'b1, 1'b0, "R10 far below");
    // R1 hold: a known word, then other data without a strobe
    send(3'd1, 1'b0, 0, mk(23'h3, 37'h0), 2'd0, 32'h3F800003, 1'b0, 1'b0, "R1 load");
    idle();
    in_class = 3'd2;
    in_sign  = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'h3F800003) begin
      errors++;
      $display("FAIL R1 hold: got v=%b w=%h expected v=0 w=3F800003", out_valid, out_word);
    end
    // R1 back-to-back strobes after idle
    send(3'd0, 1'b0, 0, 64'h0, 2'd0, 32'h00000000, 1'b0, 1'b0, "R1 restart a");
    send(3'd2, 1'b1, 0, 64'h0, 2'd0, 32'hFF800000, 1'b0, 1'b0, "R1 restart b");
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 drain: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule